// File: doc/BRIEF.md
# Nested Four-Level Interrupt Arbiter

This block decides, once per clock, whether a small 8-bit core should take an interrupt now and which one. Every cycle it looks at the request flags, masks them with per-source enables and a global enable, and gives each source a level from two bits (a high bit and a low bit). The most urgent pending source wins. A call is raised only when the core is at an instruction boundary, the current instruction neither changes interrupt configuration nor returns from a handler, and no handler of the same or a higher level is running.

The block keeps one in-service bit per level. A call marks its level busy. Only the interrupt-return indication frees a level, and it frees the highest busy one, so handlers nest properly. A request that is refused is not kept: the next cycle looks at the flags afresh. The output is a one-cycle call pulse, registered together with the vector address and the index of the source that won. Pushing the return address, reloading the program counter and clearing flags are left to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Requests are sampled on every clock. When a cycle qualifies, `call_req` is high for exactly the following cycle.
- R2: A source's level is `{prio_hi[i], prio_lo[i]}`. Level 3 is the most urgent and level 0 the least. The highest pending level wins.
- R3: When several pending sources share the winning level, the one with the lowest index wins.
- R4: No call is issued in a cycle where `instr_last` is low.
- R5: No call is issued in a cycle where `cfg_write` or `reti_exec` is high.
- R6: A refused request is not remembered. If its flag has dropped by the time the blocking condition ends, no call is issued for it.
- R7: A call is issued only if no level is in service, or if the winning level is strictly above every level in service.
- R8: Issuing a call marks its level in service. A cycle with `reti_exec` high clears only the highest level in service and leaves any lower levels marked.
- R9: The in-service state changes only when a call is issued or when `reti_exec` is high. Without `reti_exec` (for example after a plain return), a level stays busy and keeps blocking requests of equal or lower level.
- R10: While `call_req` is high, `call_src` holds the winning index and `call_vec` equals `VEC_BASE + 8*call_src` (default base 3).
- R11: A source whose `irq_en` bit is low is ignored. All sources are ignored while `glob_en` is low.
- R12: While reset is active, and afterwards until the first call, `call_req`, `call_vec` and `call_src` are zero and no level is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_flag | input | N_SRC | Request flag per source |
| irq_en | input | N_SRC | Enable per source |
| glob_en | input | 1 | Global interrupt enable |
| prio_hi | input | N_SRC | Level high bit per source |
| prio_lo | input | N_SRC | Level low bit per source |
| instr_last | input | 1 | Current cycle is the last cycle of the executing instruction |
| cfg_write | input | 1 | Current instruction writes an enable or level bit |
| reti_exec | input | 1 | Current instruction is an interrupt return |
| call_req | output | 1 | One-cycle request to perform the interrupt call |
| call_vec | output | VEC_W | Vector address of the chosen source |
| call_src | output | IDX_W | Index of the chosen source |

## Verification
A wrong in-service bit has only one effect at the ports: it changes which later requests are allowed through. A bit that stays set when it should be clear swallows the next call of that level. A bit that is lost lets a same-level request through one cycle after the first call. The bench therefore follows every call with a same-level request, a higher-level request, plain-return cycles and single interrupt-return cycles. A fault in the level decoding or in the tie-break shows up in the `call_src` and `call_vec` of the very next call pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0]              irq_flag,
  input  logic [N_SRC-1:0]              irq_en,
  input  logic                          glob_en,
  input  logic [N_SRC-1:0]              prio_hi,
  input  logic [N_SRC-1:0]              prio_lo,
  output logic [NUM_LVL-1:0][N_SRC-1:0] lvl_req
);
  logic [N_SRC-1:0] live;

  assign live = irq_flag & irq_en & {N_SRC{glob_en}};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    lvl_t s_lvl;
    assign s_lvl = {prio_hi[s], prio_lo[s]};
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      assign lvl_req[l][s] = live[s] && (s_lvl == lvl_t'(l));
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [NUM_LVL-1:0][N_SRC-1:0] lvl_req,
  output logic                          any_req,
  output lvl_t                          win_lvl,
  output logic [IDX_W-1:0]              win_idx
);
  lvl_vec_t         lvl_any;
  logic [N_SRC-1:0] top_row;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_any
    assign lvl_any[l] = |lvl_req[l];
  end

  always_comb begin
    win_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_any[l]) win_lvl = lvl_t'(l);
    end
  end

  assign any_req = |lvl_any;
  assign top_row = lvl_req[win_lvl];

  always_comb begin
    win_idx = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (top_row[s]) win_idx = IDX_W'(s);
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_en,
  input  lvl_t     set_lvl,
  input  logic     rel_en,
  output lvl_vec_t ins_q,
  output logic     busy,
  output lvl_t     top_lvl
);
  lvl_vec_t ins_d;
  lvl_vec_t top_oh;

  always_comb begin
    top_lvl = '0;
    top_oh  = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (ins_q[l]) begin
        top_lvl = lvl_t'(l);
        top_oh  = lvl_vec_t'(1) << l;
      end
    end
  end

  assign busy = |ins_q;

  always_comb begin
    ins_d = ins_q;
    if (rel_en) ins_d = ins_d & ~top_oh;
    if (set_en) ins_d = ins_d | (lvl_vec_t'(1) << set_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= '0;
    end else if (set_en || rel_en) begin
      ins_q <= ins_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int          N_SRC    = 8,
  parameter int          IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_flag,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             glob_en,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic [N_SRC-1:0] prio_lo,
  input  logic             instr_last,
  input  logic             cfg_write,
  input  logic             reti_exec,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic [IDX_W-1:0] call_src
);
  localparam int STEP_SH = 3;

  logic [1:0]                    rst_pipe;
  logic                          rst_core_n;
  logic [NUM_LVL-1:0][N_SRC-1:0] lvl_req;
  logic                          any_req;
  lvl_t                          win_lvl;
  logic [IDX_W-1:0]              win_idx;
  lvl_vec_t                      ins_q;
  logic                          busy;
  lvl_t                          top_lvl;
  logic                          boundary_ok;
  logic                          level_ok;
  logic                          fire;
  logic                          rel;
  logic [VEC_W-1:0]              vec_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  irq_level_map #(.N_SRC(N_SRC)) map_i (
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .glob_en  (glob_en),
    .prio_hi  (prio_hi),
    .prio_lo  (prio_lo),
    .lvl_req  (lvl_req)
  );

  irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) pick_i (
    .lvl_req  (lvl_req),
    .any_req  (any_req),
    .win_lvl  (win_lvl),
    .win_idx  (win_idx)
  );

  assign boundary_ok = instr_last && !cfg_write && !reti_exec;
  assign level_ok    = !busy || (win_lvl > top_lvl);
  assign fire        = boundary_ok && any_req && level_ok;
  assign rel         = reti_exec;

  irq_inservice isv_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_en  (fire),
    .set_lvl (win_lvl),
    .rel_en  (rel),
    .ins_q   (ins_q),
    .busy    (busy),
    .top_lvl (top_lvl)
  );

  assign vec_d = VEC_W'(VEC_BASE) + VEC_W'({win_idx, {STEP_SH{1'b0}}});

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      call_req <= 1'b0;
    end else begin
      call_req <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      call_vec <= '0;
      call_src <= '0;
    end else if (fire) begin
      call_vec <= vec_d;
      call_src <= win_idx;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
#(
  parameter int          N_SRC    = 8,
  parameter int          IDX_W    = 3,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_flag,
  input logic [N_SRC-1:0] irq_en,
  input logic             glob_en,
  input logic [N_SRC-1:0] prio_hi,
  input logic [N_SRC-1:0] prio_lo,
  input logic             instr_last,
  input logic             cfg_write,
  input logic             reti_exec,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec,
  input logic [IDX_W-1:0] call_src,
  input lvl_vec_t         ins_q
);
  logic [N_SRC-1:0] live_d;
  logic [N_SRC-1:0] hi_d;
  logic [N_SRC-1:0] lo_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_d <= '0;
      hi_d   <= '0;
      lo_d   <= '0;
    end else begin
      live_d <= irq_flag & irq_en & {N_SRC{glob_en}};
      hi_d   <= prio_hi;
      lo_d   <= prio_lo;
    end
  end

  // R4, R5: a call follows only a clean instruction boundary
  assert_call_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(instr_last && !cfg_write && !reti_exec));

  // R11: the chosen source was enabled and requesting
  assert_call_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> live_d[call_src]);

  // R10: vector tracks the chosen index
  assert_vec_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == VEC_W'(VEC_BASE) + VEC_W'(call_src) * VEC_W'(8)));

  // R8: the level of the issued call is marked in service
  assert_level_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> ins_q[{hi_d[call_src], lo_d[call_src]}]);

  // R9: in-service state moves only on a call or an interrupt return
  assert_ins_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_q != $past(ins_q)) |-> (call_req || $past(reti_exec)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .N_SRC(N_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en),
  .glob_en(glob_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
  .instr_last(instr_last), .cfg_write(cfg_write), .reti_exec(reti_exec),
  .call_req(call_req), .call_vec(call_vec), .call_src(call_src),
  .ins_q(ins_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int VW    = 16;
  localparam int BASE  = 3;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  flg, en, hi, lo;
  logic          glob, last, wr, reti;
  logic          call_req;
  logic [VW-1:0] call_vec;
  logic [IW-1:0] call_src;
  int            n_run, n_fail;
  bit            done;

  irq_prio_ctrl #(.N_SRC(N), .IDX_W(IW), .VEC_W(VW), .VEC_BASE(16'h0003)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_flag(flg), .irq_en(en), .glob_en(glob),
    .prio_hi(hi), .prio_lo(lo), .instr_last(last), .cfg_write(wr),
    .reti_exec(reti), .call_req(call_req), .call_vec(call_vec), .call_src(call_src)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic req(input int idx, input int lvl);
    flg[idx] = 1'b1;
    hi[idx]  = lvl[1];
    lo[idx]  = lvl[0];
  endtask

  task automatic expect_call(input bit exp_req, input int exp_src, input string tag);
    n_run++;
    if (call_req !== exp_req) begin
      n_fail++;
      $display("FAIL %s call_req act=%0b exp=%0b", tag, call_req, exp_req);
    end else if (exp_req) begin
      if (call_src !== IW'(exp_src) || call_vec !== VW'(BASE + 8 * exp_src)) begin
        n_fail++;
        $display("FAIL %s src/vec act=%0d/%0d exp=%0d/%0d", tag,
                 call_src, call_vec, exp_src, BASE + 8 * exp_src);
      end
    end
  endtask

  task automatic drain();
    flg = '0; last = 1'b0; reti = 1'b1;
    repeat (4) tick();
    reti = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    flg = '1; en = '1; hi = '1; lo = '1; glob = 1'b1; last = 1'b1; wr = 1'b0; reti = 1'b0;
    repeat (3) tick();
    n_run++;
    if (call_req !== 1'b0 || call_vec !== '0 || call_src !== '0) begin
      n_fail++;
      $display("FAIL R12 reset outputs act=%0b/%0d/%0d exp=0/0/0", call_req, call_vec, call_src);
    end
    flg = '0; hi = '0; lo = '0;
    rst_n = 1'b1;
    repeat (4) tick();
    expect_call(1'b0, 0, "R12 idle after reset");
  endtask

  task automatic t_basic();
    last = 1'b1;
    req(2, 1);
    tick(); expect_call(1'b1, 2, "R1 first call");
    tick(); expect_call(1'b0, 0, "R7 same level blocked");
    tick(); expect_call(1'b0, 0, "R1 pulse stays low");
    flg = '0; reti = 1'b1;
    tick(); expect_call(1'b0, 0, "R5 no call during reti");
    reti = 1'b0; req(2, 1);
    tick(); expect_call(1'b1, 2, "R8 level released by reti");
    drain();
  endtask

  task automatic t_priority();
    last = 1'b1;
    req(1, 1); req(5, 3); req(6, 3); req(0, 2);
    tick(); expect_call(1'b1, 5, "R2 R3 top level lowest index");
    drain();
    last = 1'b1;
    req(7, 2); req(3, 1);
    tick(); expect_call(1'b1, 7, "R2 R10 highest index vector");
    drain();
    last = 1'b1;
    req(4, 0); req(6, 0);
    tick(); expect_call(1'b1, 4, "R3 tie at level 0");
    drain();
  endtask

  task automatic t_gates();
    req(3, 2); last = 1'b0;
    tick(); expect_call(1'b0, 0, "R4 mid-instruction");
    last = 1'b1; wr = 1'b1;
    tick(); expect_call(1'b0, 0, "R5 config write");
    wr = 1'b0; reti = 1'b1;
    tick(); expect_call(1'b0, 0, "R5 reti blocks");
    reti = 1'b0; flg = '0;
    tick(); expect_call(1'b0, 0, "R6 dropped flag not kept");
    tick(); expect_call(1'b0, 0, "R6 still nothing");
    drain();
  endtask

  task automatic t_enable();
    last = 1'b1; en = 8'b1111_1011; req(2, 3);
    tick(); expect_call(1'b0, 0, "R11 source disabled");
    en = '1; glob = 1'b0;
    tick(); expect_call(1'b0, 0, "R11 global disable");
    glob = 1'b1;
    tick(); expect_call(1'b1, 2, "R11 enabled again");
    drain();
  endtask

  task automatic t_nesting();
    last = 1'b1; req(0, 0);
    tick(); expect_call(1'b1, 0, "R8 level 0 call");
    flg = '0; req(3, 2);
    tick(); expect_call(1'b1, 3, "R7 preempt by level 2");
    flg = '0; req(4, 2);
    tick(); expect_call(1'b0, 0, "R7 equal level blocked");
    flg = '0;
    repeat (3) tick();
    req(4, 2);
    tick(); expect_call(1'b0, 0, "R9 plain return keeps level");
    flg = '0; reti = 1'b1;
    tick(); expect_call(1'b0, 0, "R5 reti cycle");
    reti = 1'b0; req(4, 2);
    tick(); expect_call(1'b1, 4, "R8 level 2 released");
    flg = '0; reti = 1'b1;
    tick();
    reti = 1'b0; req(1, 0);
    tick(); expect_call(1'b0, 0, "R8 lower level still busy");
    flg = '0; reti = 1'b1;
    tick();
    reti = 1'b0; req(1, 0);
    tick(); expect_call(1'b1, 1, "R8 all levels released");
    drain();
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_basic();
    t_priority();
    t_gates();
    t_enable();
    t_nesting();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule